// File: doc/BRIEF.md
# Grouped Interrupt Request Aggregator

This block gathers single-cycle event pulses from peripheral logic into twelve groups. Each group holds seven sticky request flags. A flag goes to 1 when its source fires. It stays at 1 until software clears it with an AND-mask write. Accepting the interrupt does not clear it.

Each group has one configuration register that holds a seven-bit source enable mask and a routing bit. With the routing bit at 1, any enabled flag latches a per-group CPU pending flag. That flag drops only on an acknowledge pulse for the group. While it is pending, the group presents vector number 44 plus its index. With the routing bit at 0, the enabled flags instead drive a single-cycle DMA trigger pulse.

Software reaches the flags and the configuration through a small register port. Writes take one cycle. Reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: After synchronous reset, every request flag, configuration register, pending flag, vector output and DMA trigger is 0.
- R2: An event pulse on source bit b (1 to 7) of group g sets request flag b of group g on the next clock edge. Source bit 0 of every group is ignored, and flag bit 0 always reads 0.
- R3: A write with `wr_sel`=0 to group g updates that group's flags as flags AND `wr_data`: a 0 clears a bit and a 1 keeps it. No other group changes.
- R4: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: With routing bit (config bit 0) at 1, the group's pending flag becomes 1 on the clock edge after any flag whose enable bit (config bit b for flag b) is 1 reads 1. Flags with enable 0 never set it.
- R6: A pending flag stays 1 until the group's acknowledge. Further enabled events do not change it.
- R7: An acknowledge pulse clears the group's pending flag on that edge and leaves the request flags unchanged. The pending flag sets again on the following edge only if an enabled flag is still 1.
- R8: With routing bit at 0, the group never becomes pending. Its DMA trigger is high for exactly one cycle, in the cycle after the OR of its enabled flags rises.
- R9: While group g is pending, its 6-bit vector field in `irq_vec` (bits 6g+5:6g) holds 44+g. Otherwise the field holds 0.
- R10: An event on a flag that is already 1 has no effect: the flag read is unchanged and no further DMA trigger occurs.
- R11: A write with `wr_sel`=1 stores `wr_data` as the group's configuration. A read with `rd_sel`=1 returns it. A read with `rd_sel`=0 returns the request flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 96 | Event pulses, 8 bits per group (bit 8g+b is source b of group g) |
| grp_ack | input | 12 | One-cycle acknowledge per group |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: AND-clear request flags, 1: write configuration |
| wr_grp | input | 4 | Group addressed by the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | 0: read request flags, 1: read configuration |
| rd_grp | input | 4 | Group addressed by the read |
| rd_data | output | 8 | Combinational read data |
| irq_pend | output | 12 | CPU pending flag per group |
| irq_vec | output | 72 | 6-bit vector per group, 44+g while pending |
| dma_trig | output | 12 | One-cycle DMA trigger per group |

## Verification
The assertions assume that acknowledge pulses and software writes are sampled on the same edge as events. They also assume that an acknowledge is given only in a cycle where the bench expects its effect. The hold property exempts the cycle in which an acknowledge is present.

The stimulus drives every input on the falling clock edge and holds it for one full cycle. It uses only group numbers 0 to 11 for writes. It changes a group's configuration only while that group's flags are zero, so the routing mode never switches under an active request.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NUM_GROUPS = 12;
    localparam int SRC_W      = 8;
    localparam int VEC_BASE   = 44;
    localparam int VEC_W      = 6;
    localparam int GRP_W      = $clog2(NUM_GROUPS);

    typedef struct packed {
        logic [SRC_W-1:1] en;
        logic             to_cpu;
    } grp_cfg_t;

    typedef enum logic {
        SEL_REQ = 1'b0,
        SEL_CFG = 1'b1
    } reg_sel_e;

    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        return VEC_W'(VEC_BASE + idx);
    endfunction

    function automatic logic [SRC_W-1:0] valid_bits();
        return {{(SRC_W-1){1'b1}}, 1'b0};
    endfunction
endpackage

// File: rtl/irq_req_flags.sv
module irq_req_flags
    import irq_agg_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] req
);
    localparam logic [W-1:0] VALID = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0] keep_mask;
    logic [W-1:0] evt_m;

    always_comb begin
        keep_mask = clr_en ? clr_mask : '1;
        evt_m     = evt & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) req <= '0;
        else     req <= ((req & keep_mask) | evt_m) & VALID;
    end

    // R4
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_m) |=> ((req & $past(evt_m)) == $past(evt_m)));

    // R3
    no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((req & $past(req)) == $past(req)));
endmodule

// File: rtl/irq_grp_route.sv
module irq_grp_route
    import irq_agg_pkg::*;
#(
    parameter int W       = SRC_W,
    parameter int VW      = VEC_W,
    parameter int VEC_NUM = VEC_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  req,
    input  grp_cfg_t      cfg,
    input  logic          ack,
    output logic          pend,
    output logic          trig,
    output logic [VW-1:0] vec
);
    logic act;
    logic dma_act;
    logic dma_q;

    always_comb begin
        act     = |(req[W-1:1] & cfg.en);
        dma_act = act & ~cfg.to_cpu;
        trig    = dma_act & ~dma_q;
        vec     = pend ? VW'(VEC_NUM) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            dma_q <= 1'b0;
        end else begin
            dma_q <= dma_act;
            if (ack)                    pend <= 1'b0;
            else if (cfg.to_cpu && act) pend <= 1'b1;
        end
    end

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.to_cpu && act && !ack) |=> pend);

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !pend);

    // R8
    dma_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.to_cpu && !pend) |=> !pend);

    // R8
    trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int G  = NUM_GROUPS,
    parameter int W  = SRC_W,
    parameter int VW = VEC_W,
    parameter int GW = GRP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [G*W-1:0]  src_evt,
    input  logic [G-1:0]    grp_ack,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [GW-1:0]   wr_grp,
    input  logic [W-1:0]    wr_data,
    input  logic            rd_sel,
    input  logic [GW-1:0]   rd_grp,
    output logic [W-1:0]    rd_data,
    output logic [G-1:0]    irq_pend,
    output logic [G*VW-1:0] irq_vec,
    output logic [G-1:0]    dma_trig
);
    grp_cfg_t     cfg_q [G];
    logic [W-1:0] req_q [G];

    for (genvar g = 0; g < G; g++) begin : g_grp
        localparam logic [GW-1:0] GIDX = GW'(g);
        logic hit;
        logic clr_en;

        always_comb begin
            hit    = wr_en && (wr_grp == GIDX);
            clr_en = hit && (reg_sel_e'(wr_sel) == SEL_REQ);
        end

        always_ff @(posedge clk) begin
            if (rst)                                      cfg_q[g] <= '0;
            else if (hit && reg_sel_e'(wr_sel) == SEL_CFG) cfg_q[g] <= grp_cfg_t'(wr_data);
        end

        irq_req_flags #(.W(W)) u_flags (
            .clk      (clk),
            .rst      (rst),
            .evt      (src_evt[g*W +: W]),
            .clr_en   (clr_en),
            .clr_mask (wr_data),
            .req      (req_q[g])
        );

        irq_grp_route #(.W(W), .VW(VW), .VEC_NUM(VEC_BASE + g)) u_route (
            .clk  (clk),
            .rst  (rst),
            .req  (req_q[g]),
            .cfg  (cfg_q[g]),
            .ack  (grp_ack[g]),
            .pend (irq_pend[g]),
            .trig (dma_trig[g]),
            .vec  (irq_vec[g*VW +: VW])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < G; g++) begin
            if (rd_grp == GW'(g)) begin
                rd_data = (reg_sel_e'(rd_sel) == SEL_CFG) ? W'(cfg_q[g]) : req_q[g];
            end
        end
    end
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
    localparam int G = 12;
    localparam int W = 8;
    localparam int VW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [G*W-1:0]  src_evt = '0;
    logic [G-1:0]    grp_ack = '0;
    logic            wr_en = 1'b0;
    logic            wr_sel = 1'b0;
    logic [3:0]      wr_grp = '0;
    logic [W-1:0]    wr_data = '0;
    logic            rd_sel = 1'b0;
    logic [3:0]      rd_grp = '0;
    logic [W-1:0]    rd_data;
    logic [G-1:0]    irq_pend;
    logic [G*VW-1:0] irq_vec;
    logic [G-1:0]    dma_trig;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] exp_req [G];

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst(rst), .src_evt(src_evt), .grp_ack(grp_ack),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_grp(wr_grp), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_grp(rd_grp), .rd_data(rd_data),
        .irq_pend(irq_pend), .irq_vec(irq_vec), .dma_trig(dma_trig)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input int g, input int b);
        src_evt[g*W + b] = 1'b1;
        cyc();
        src_evt = '0;
    endtask

    task automatic wr(input logic sel, input int g, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_grp = 4'(g); wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input int g, output logic [7:0] d);
        rd_sel = sel; rd_grp = 4'(g);
        #1;
        d = rd_data;
    endtask

    task automatic ack(input int g);
        grp_ack[g] = 1'b1;
        cyc();
        grp_ack = '0;
    endtask

    initial begin
        logic [7:0] d;
        @(negedge clk);
        cyc();
        cyc();
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state everywhere
        for (int g = 0; g < G; g++) begin
            rd(1'b0, g, d); chk("R1 flags", d, 0);
            rd(1'b1, g, d); chk("R1 cfg", d, 0);
            exp_req[g] = 8'h00;
        end
        chk("R1 pend", int'(irq_pend), 0);
        chk("R1 vec", int'(irq_vec != '0), 0);
        chk("R1 trig", int'(dma_trig), 0);

        // R2 R10 R3: fill each group bit by bit, then mask-clear
        for (int g = 0; g < G; g++) begin
            for (int b = 0; b < W; b++) begin
                fire(g, b);
                if (b != 0) exp_req[g][b] = 1'b1;
                rd(1'b0, g, d); chk("R2 set flag", d, exp_req[g]);
            end
            fire(g, 1);
            rd(1'b0, g, d); chk("R10 repeat event", d, exp_req[g]);
            rd(1'b0, (g + 1) % G, d); chk("R3 other group", d, 0);
            wr(1'b0, g, 8'hA5);
            exp_req[g] = exp_req[g] & 8'hA5;
            rd(1'b0, g, d); chk("R3 and clear", d, exp_req[g]);
            wr(1'b0, g, 8'h00);
            exp_req[g] = 8'h00;
            rd(1'b0, g, d); chk("R3 full clear", d, 0);
            chk("R8 no trig when disabled", int'(dma_trig), 0);
        end

        // R4: set wins over same-cycle clear
        for (int g = 0; g < G; g++) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_grp = 4'(g); wr_data = 8'h00;
            src_evt[g*W + 4] = 1'b1;
            cyc();
            wr_en = 1'b0; src_evt = '0;
            rd(1'b0, g, d); chk("R4 set wins", d, 8'h10);
            wr(1'b0, g, 8'h00);
        end

        // R5 R6 R7 R9 R11: CPU routing
        for (int g = 0; g < G; g++) begin
            wr(1'b1, g, 8'h09);
            rd(1'b1, g, d); chk("R11 cfg readback", d, 8'h09);
            fire(g, 5);
            cyc();
            chk("R5 disabled no pend", int'(irq_pend[g]), 0);
            fire(g, 3);
            chk("R5 not yet pending", int'(irq_pend[g]), 0);
            cyc();
            chk("R5 pending", int'(irq_pend), 1 << g);
            chk("R9 vector", int'(irq_vec[g*VW +: VW]), 44 + g);
            fire(g, 7);
            chk("R6 hold", int'(irq_pend[g]), 1);
            ack(g);
            chk("R7 ack clears", int'(irq_pend[g]), 0);
            chk("R9 vector idle", int'(irq_vec[g*VW +: VW]), 0);
            rd(1'b0, g, d); chk("R7 flags kept", d, 8'hA8);
            cyc();
            chk("R7 re-pend", int'(irq_pend[g]), 1);
            wr(1'b0, g, 8'h00);
            ack(g);
            cyc();
            chk("R7 stays clear", int'(irq_pend[g]), 0);
            wr(1'b1, g, 8'h00);
        end

        // R8 R10: DMA routing
        for (int g = 0; g < G; g++) begin
            wr(1'b1, g, 8'h40);
            fire(g, 6);
            chk("R8 trig pulse", int'(dma_trig), 1 << g);
            cyc();
            chk("R8 trig one cycle", int'(dma_trig), 0);
            chk("R8 no pend", int'(irq_pend), 0);
            fire(g, 6);
            chk("R10 no retrigger", int'(dma_trig), 0);
            wr(1'b0, g, 8'h00);
            fire(g, 2);
            chk("R8 disabled src", int'(dma_trig), 0);
            fire(g, 6);
            chk("R8 second pulse", int'(dma_trig), 1 << g);
            wr(1'b0, g, 8'h00);
            wr(1'b1, g, 8'h00);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule